// File: doc/BRIEF.md
# I3C Target Address Match Unit

This block decides which of two target identities an incoming I3C address header selects. One identity is the main target. The other is a virtual target whose traffic is steered to a recovery path. Each identity keeps a 7-bit static address and a 7-bit dynamic address, and each address has its own valid flag. A received header address is compared against both identities in the same cycle. The result is a registered one-cycle select pulse: main, virtual or no match. The read/write bit travels with the pulse.

The address registers are written through a simple configuration port and updated by address-assignment events that an external command decoder reports. Once an identity holds a valid dynamic address, its static address stops matching. The block also produces the address and valid flag used for in-band interrupts, taken from the main identity only. It masks a pending interrupt request while that identity has no valid address. While a virtual-target transaction is in progress, it also suppresses the normal queue interrupt.

Top module: `addr_match_unit`

## Requirements
- R1: When an identity's dynamic-valid flag is set, it matches only its dynamic address; a header equal to its static address does not select it.
- R2: When an identity's dynamic-valid flag is clear and its static-valid flag is set, it matches its static address; with both flags clear it matches nothing.
- R3: Both identities are evaluated on the same header. One cycle after `hdr_vld_i`, `sel_vld_o` pulses high and exactly one of `sel_main_o`, `sel_virt_o`, `sel_none_o` is set with it; all four are low otherwise.
- R4: If both identities match the same header address, `sel_main_o` is reported and `sel_virt_o` stays low.
- R5: `sel_rnw_o` carries the `hdr_rnw_i` value of the header that produced the current `sel_vld_o` pulse.
- R6: After a header selects the virtual identity, `q_irq_o` is forced low regardless of `q_irq_i` until a later header selects the main identity or nothing; otherwise `q_irq_o` follows `q_irq_i`.
- R7: `ibi_addr_o` equals the main identity's dynamic address when its dynamic-valid flag is set, and its static address otherwise; the virtual identity never affects it.
- R8: `ibi_addr_vld_o` is the OR of the main identity's two valid flags, and `ibi_pend_o` is `ibi_req_i` gated by `ibi_addr_vld_o`.
- R9: A configuration write (`cfg_we_i`) loads `cfg_addr_i` and `cfg_vld_i` into one register of the identity chosen by `cfg_id_i` (0 main, 1 virtual): the static register when `cfg_kind_i` is 0 and the dynamic register when it is 1. The new value is used from the next cycle.
- R10: Assignment events with `evt_code_i` 0 (full assignment), 1 (set from static) and 3 (set new address) load `evt_addr_i` into the dynamic address of identity `evt_id_i` and set its dynamic-valid flag. Code 2 (set all from static) is broadcast: each identity whose static address is valid copies that address into its dynamic register and sets dynamic-valid, and each identity without a valid static address is left unchanged.
- R11: Event code 4 clears the dynamic-valid flag of identity `evt_id_i`, so that identity falls back to static matching. Codes 5 to 7 have no effect.
- R12: When an event and a dynamic-register configuration write hit the same identity in the same cycle, the event's result is kept.
- R13: After reset all valid flags are clear, the addresses are zero, and the select, interrupt-valid and pending outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_id_i | input | 1 | Identity to write: 0 main, 1 virtual |
| cfg_kind_i | input | 1 | Register to write: 0 static, 1 dynamic |
| cfg_addr_i | input | 7 | Address to load |
| cfg_vld_i | input | 1 | Valid flag to load |
| evt_vld_i | input | 1 | Assignment event strobe |
| evt_code_i | input | 3 | Event kind (see R10, R11) |
| evt_id_i | input | 1 | Identity addressed by a directed event |
| evt_addr_i | input | 7 | Address carried by the event |
| hdr_vld_i | input | 1 | Header address strobe |
| hdr_addr_i | input | 7 | Received 7-bit header address |
| hdr_rnw_i | input | 1 | Received read/write bit |
| q_irq_i | input | 1 | Queue interrupt from the normal data path |
| ibi_req_i | input | 1 | In-band interrupt request |
| sel_vld_o | output | 1 | Match result valid pulse |
| sel_main_o | output | 1 | Main identity selected |
| sel_virt_o | output | 1 | Virtual identity selected |
| sel_none_o | output | 1 | No identity selected |
| sel_rnw_o | output | 1 | Read/write bit of the matched header |
| q_irq_o | output | 1 | Queue interrupt after virtual-transaction gating |
| ibi_addr_o | output | 7 | In-band interrupt address |
| ibi_addr_vld_o | output | 1 | In-band interrupt address valid |
| ibi_pend_o | output | 1 | Request pending after masking |

## Verification
The assertions assume that `hdr_vld_i` is a single-cycle strobe whose address and read/write bit are stable in that cycle. They also assume that the configuration and event strobes are synchronous and free of unknown values after reset. The bench drives every input on the falling edge, raises each strobe for exactly one cycle, and keeps header probes apart from register updates. The only exception is the deliberate collision test for R12, where an event and a configuration write land in the same cycle. The bench model therefore always compares against a settled register state.

// File: rtl/addr_match_pkg.sv
package addr_match_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned N_ID   = 2;
  localparam int unsigned EVT_W  = 3;

  typedef enum logic [EVT_W-1:0] {
    EV_FULL    = 3'd0,
    EV_FROM_ST = 3'd1,
    EV_ALL_ST  = 3'd2,
    EV_NEW     = 3'd3,
    EV_RST_DYN = 3'd4
  } evt_code_e;

  typedef struct packed {
    logic [ADDR_W-1:0] sta;
    logic              sta_v;
    logic [ADDR_W-1:0] dyn;
    logic              dyn_v;
  } ident_t;
endpackage

// File: rtl/addr_ident_regs.sv
module addr_ident_regs
  import addr_match_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_kind_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic              cfg_vld_i,
  input  logic              evt_vld_i,
  input  logic              evt_hit_i,
  input  logic [EVT_W-1:0]  evt_code_i,
  input  logic [ADDR_W-1:0] evt_addr_i,
  output ident_t            id_o
);
  ident_t    id_q;
  evt_code_e code;
  logic      dir_load, all_load, dyn_clr, cfg_sta, cfg_dyn;

  assign code     = evt_code_e'(evt_code_i);
  assign dir_load = evt_vld_i && evt_hit_i &&
                    (code == EV_FULL || code == EV_FROM_ST || code == EV_NEW);
  assign all_load = evt_vld_i && code == EV_ALL_ST && id_q.sta_v;
  assign dyn_clr  = evt_vld_i && evt_hit_i && code == EV_RST_DYN;
  assign cfg_sta  = cfg_we_i && !cfg_kind_i;
  assign cfg_dyn  = cfg_we_i &&  cfg_kind_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q <= '0;
    end else begin
      if (cfg_sta) begin
        id_q.sta   <= cfg_addr_i;
        id_q.sta_v <= cfg_vld_i;
      end
      // events outrank configuration writes on the dynamic register
      if (dir_load) begin
        id_q.dyn   <= evt_addr_i;
        id_q.dyn_v <= 1'b1;
      end else if (all_load) begin
        id_q.dyn   <= id_q.sta;
        id_q.dyn_v <= 1'b1;
      end else if (dyn_clr) begin
        id_q.dyn_v <= 1'b0;
      end else if (cfg_dyn) begin
        id_q.dyn   <= cfg_addr_i;
        id_q.dyn_v <= cfg_vld_i;
      end
    end
  end

  assign id_o = id_q;

  assert_dir_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_load |=> id_q.dyn_v && id_q.dyn == $past(evt_addr_i));
  assert_all_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_load |=> id_q.dyn_v && id_q.dyn == $past(id_q.sta));
  assert_dyn_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dyn_clr |=> !id_q.dyn_v);
  assert_evt_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_load && cfg_dyn) |=> id_q.dyn == $past(evt_addr_i));
  assert_cfg_sta_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_sta |=> id_q.sta == $past(cfg_addr_i) && id_q.sta_v == $past(cfg_vld_i));
endmodule

// File: rtl/addr_ident_cmp.sv
module addr_ident_cmp
  import addr_match_pkg::*;
(
  input  ident_t            id_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic dyn_eq, sta_eq;

  assign dyn_eq = (addr_i == id_i.dyn);
  assign sta_eq = (addr_i == id_i.sta);

  // a valid dynamic address shadows the static one
  always_comb begin
    if (id_i.dyn_v)      hit_o = dyn_eq;
    else if (id_i.sta_v) hit_o = sta_eq;
    else                 hit_o = 1'b0;
  end
endmodule

// File: rtl/addr_match_unit.sv
module addr_match_unit
  import addr_match_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_id_i,
  input  logic              cfg_kind_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic              cfg_vld_i,
  input  logic              evt_vld_i,
  input  logic [EVT_W-1:0]  evt_code_i,
  input  logic              evt_id_i,
  input  logic [ADDR_W-1:0] evt_addr_i,
  input  logic              hdr_vld_i,
  input  logic [ADDR_W-1:0] hdr_addr_i,
  input  logic              hdr_rnw_i,
  input  logic              q_irq_i,
  input  logic              ibi_req_i,
  output logic              sel_vld_o,
  output logic              sel_main_o,
  output logic              sel_virt_o,
  output logic              sel_none_o,
  output logic              sel_rnw_o,
  output logic              q_irq_o,
  output logic [ADDR_W-1:0] ibi_addr_o,
  output logic              ibi_addr_vld_o,
  output logic              ibi_pend_o
);
  localparam int unsigned MAIN = 0;
  localparam int unsigned VIRT = 1;

  ident_t           ids  [N_ID];
  logic [N_ID-1:0]  hits;

  for (genvar g = 0; g < N_ID; g++) begin : g_id
    logic cfg_sel, evt_sel;
    assign cfg_sel = (cfg_id_i == 1'(g));
    assign evt_sel = (evt_id_i == 1'(g));

    addr_ident_regs u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we_i && cfg_sel),
      .cfg_kind_i (cfg_kind_i),
      .cfg_addr_i (cfg_addr_i),
      .cfg_vld_i  (cfg_vld_i),
      .evt_vld_i  (evt_vld_i),
      .evt_hit_i  (evt_sel),
      .evt_code_i (evt_code_i),
      .evt_addr_i (evt_addr_i),
      .id_o       (ids[g])
    );

    addr_ident_cmp u_cmp (
      .id_i   (ids[g]),
      .addr_i (hdr_addr_i),
      .hit_o  (hits[g])
    );
  end

  logic win_main, win_virt;
  logic sel_vld_q, sel_main_q, sel_virt_q, sel_none_q, sel_rnw_q, virt_act_q;

  assign win_main = hits[MAIN];
  assign win_virt = hits[VIRT] && !hits[MAIN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_vld_q  <= 1'b0;
      sel_main_q <= 1'b0;
      sel_virt_q <= 1'b0;
      sel_none_q <= 1'b0;
      sel_rnw_q  <= 1'b0;
      virt_act_q <= 1'b0;
    end else begin
      sel_vld_q  <= hdr_vld_i;
      sel_main_q <= hdr_vld_i && win_main;
      sel_virt_q <= hdr_vld_i && win_virt;
      sel_none_q <= hdr_vld_i && !win_main && !win_virt;
      sel_rnw_q  <= hdr_vld_i && hdr_rnw_i;
      if (hdr_vld_i) virt_act_q <= win_virt;
    end
  end

  assign sel_vld_o  = sel_vld_q;
  assign sel_main_o = sel_main_q;
  assign sel_virt_o = sel_virt_q;
  assign sel_none_o = sel_none_q;
  assign sel_rnw_o  = sel_rnw_q;
  assign q_irq_o    = q_irq_i && !virt_act_q;

  // interrupt address from main identity only
  assign ibi_addr_o     = ids[MAIN].dyn_v ? ids[MAIN].dyn : ids[MAIN].sta;
  assign ibi_addr_vld_o = ids[MAIN].dyn_v || ids[MAIN].sta_v;
  assign ibi_pend_o     = ibi_req_i && ibi_addr_vld_o;

  assert_sel_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_vld_o |-> $onehot({sel_main_o, sel_virt_o, sel_none_o}));
  assert_sel_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_vld_o |-> !(sel_main_o || sel_virt_o || sel_none_o || sel_rnw_o));
  assert_sel_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_vld_i |=> sel_vld_o);
  assert_main_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_vld_i && hits[MAIN] && hits[VIRT]) |=> sel_main_o && !sel_virt_o);
  assert_sta_shadow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_vld_i && ids[MAIN].dyn_v && hdr_addr_i != ids[MAIN].dyn) |=> !sel_main_o);
  assert_no_flags_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_vld_i && !ids[VIRT].dyn_v && !ids[VIRT].sta_v) |=> !sel_virt_o);
  assert_rnw_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_vld_i |=> sel_rnw_o == $past(hdr_rnw_i));
  assert_q_irq_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_virt_o |-> !q_irq_o);
  assert_ibi_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ibi_pend_o |-> ibi_addr_vld_o && ibi_req_i);
endmodule

// File: tb/sim_addr_match_unit.sv
module sim_addr_match_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 0, cfg_id_i = 0, cfg_kind_i = 0, cfg_vld_i = 0;
  logic [6:0] cfg_addr_i = '0;
  logic       evt_vld_i = 0, evt_id_i = 0;
  logic [2:0] evt_code_i = '0;
  logic [6:0] evt_addr_i = '0;
  logic       hdr_vld_i = 0, hdr_rnw_i = 0, q_irq_i = 0, ibi_req_i = 0;
  logic [6:0] hdr_addr_i = '0;
  logic       sel_vld_o, sel_main_o, sel_virt_o, sel_none_o, sel_rnw_o, q_irq_o;
  logic [6:0] ibi_addr_o;
  logic       ibi_addr_vld_o, ibi_pend_o;

  always #2 clk_i = ~clk_i;

  addr_match_unit u0 (.*);

  int errs = 0, checks = 0;
  logic [6:0] sa [2], da [2];
  logic       sv [2], dv [2];

  // {rnw, addr}
  localparam logic [7:0] PROBES [0:5] = '{8'h21, 8'hB5, 8'h42, 8'hD6, 8'h11, 8'hFF};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic model_hit(input int i, input logic [6:0] a);
    return dv[i] ? (a == da[i]) : (sv[i] && a == sa[i]);
  endfunction

  task automatic cfg_write(input logic id, input logic kind, input logic [6:0] a, input logic v);
    cfg_we_i = 1; cfg_id_i = id; cfg_kind_i = kind; cfg_addr_i = a; cfg_vld_i = v;
    @(posedge clk_i); @(negedge clk_i);
    cfg_we_i = 0;
    if (kind) begin da[id] = a; dv[id] = v; end else begin sa[id] = a; sv[id] = v; end
  endtask

  task automatic event_in(input logic [2:0] code, input logic id, input logic [6:0] a);
    evt_vld_i = 1; evt_code_i = code; evt_id_i = id; evt_addr_i = a;
    @(posedge clk_i); @(negedge clk_i);
    evt_vld_i = 0;
    case (code)
      3'd0, 3'd1, 3'd3: begin da[id] = a; dv[id] = 1; end
      3'd2: for (int i = 0; i < 2; i++) if (sv[i]) begin da[i] = sa[i]; dv[i] = 1; end
      3'd4: dv[id] = 0;
      default: ;
    endcase
  endtask

  task automatic probe(input logic [6:0] a, input logic r, input string req);
    logic m, v;
    m = model_hit(0, a);
    v = model_hit(1, a) && !m;
    hdr_vld_i = 1; hdr_addr_i = a; hdr_rnw_i = r;
    @(posedge clk_i); @(negedge clk_i);
    hdr_vld_i = 0;
    check(req, {27'd0, sel_vld_o, sel_main_o, sel_virt_o, sel_none_o, sel_rnw_o},
               {27'd0, 1'b1, m, v, !m && !v, r});
  endtask

  task automatic check_ibi(input string req);
    ibi_req_i = 1; #1;
    check(req, {23'd0, ibi_addr_o, ibi_addr_vld_o, ibi_pend_o},
               {23'd0, dv[0] ? da[0] : sa[0], sv[0] || dv[0], sv[0] || dv[0]});
    ibi_req_i = 0;
  endtask

  initial begin
    #400000;
    errs++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin sa[i] = 0; da[i] = 0; sv[i] = 0; dv[i] = 0; end
    repeat (3) @(negedge clk_i);
    // R13 reset state
    ibi_req_i = 1; #1;
    check("R13", {sel_vld_o, sel_main_o, sel_virt_o, sel_none_o, ibi_addr_vld_o, ibi_pend_o}, 0);
    ibi_req_i = 0;
    @(negedge clk_i); rst_ni = 1; @(negedge clk_i);
    check("R13", {25'd0, ibi_addr_o}, 0);

    // sweep all four valid flags (R9 loads them)
    for (int m = 0; m < 16; m++) begin
      cfg_write(0, 0, 7'h21, m[0]);
      cfg_write(0, 1, 7'h35, m[1]);
      cfg_write(1, 0, 7'h42, m[2]);
      cfg_write(1, 1, 7'h56, m[3]);
      for (int p = 0; p < 6; p++)
        probe(PROBES[p][6:0], PROBES[p][7], (m[1] || m[3]) ? "R1 R3 R5 R9" : "R2 R3 R5 R9");
      check_ibi("R7 R8");
    end

    // R4 overlap: main static and virtual dynamic equal
    cfg_write(0, 1, 7'h35, 0);
    cfg_write(0, 0, 7'h30, 1);
    cfg_write(1, 1, 7'h30, 1);
    probe(7'h30, 0, "R4");
    check("R4", {31'd0, sel_virt_o}, 0);

    // R6 queue interrupt gating
    probe(7'h30 ^ 7'h30 ^ 7'h56, 0, "R6"); // virtual dyn 0x56 replaced: none
    cfg_write(1, 1, 7'h56, 1);
    probe(7'h56, 1, "R6");
    q_irq_i = 1; #1;
    check("R6 gated", {31'd0, q_irq_o}, 0);
    @(negedge clk_i);
    check("R6 held", {31'd0, q_irq_o}, 0);
    probe(7'h30, 0, "R6");
    check("R6 released", {31'd0, q_irq_o}, 1);
    q_irq_i = 0;

    // R10 directed events
    event_in(3'd0, 0, 7'h0A);
    probe(7'h0A, 0, "R10 full");
    probe(7'h30, 0, "R1 static shadowed");
    check("R1", {31'd0, sel_main_o}, 0);
    event_in(3'd3, 1, 7'h0B);
    probe(7'h0B, 1, "R10 new");
    event_in(3'd1, 0, 7'h0C);
    probe(7'h0C, 0, "R10 from static");
    check_ibi("R7");
    // R11 reset dynamic -> static fallback
    event_in(3'd4, 0, 7'h00);
    probe(7'h30, 0, "R11");
    check("R11", {31'd0, sel_main_o}, 1);
    probe(7'h0C, 0, "R11");
    event_in(3'd6, 0, 7'h44);
    probe(7'h44, 0, "R11 unused code");
    check_ibi("R11");

    // R10 broadcast set-all: only identities with valid static
    cfg_write(1, 1, 7'h00, 0);
    cfg_write(1, 0, 7'h42, 0);
    cfg_write(0, 0, 7'h21, 1);
    event_in(3'd2, 1, 7'h7E);
    check_ibi("R10 all");
    probe(7'h21, 0, "R10 all");
    probe(7'h42, 0, "R10 all skip");
    check("R10", {31'd0, sel_none_o}, 1);

    // R12 event and config write collide on the dynamic register
    cfg_we_i = 1; cfg_id_i = 1; cfg_kind_i = 1; cfg_addr_i = 7'h66; cfg_vld_i = 1;
    evt_vld_i = 1; evt_code_i = 3'd0; evt_id_i = 1; evt_addr_i = 7'h67;
    @(posedge clk_i); @(negedge clk_i);
    cfg_we_i = 0; evt_vld_i = 0;
    da[1] = 7'h67; dv[1] = 1;
    probe(7'h67, 0, "R12");
    check("R12", {31'd0, sel_virt_o}, 1);
    probe(7'h66, 0, "R12");

    // R8 masking with no main address
    cfg_write(0, 0, 7'h21, 0);
    event_in(3'd4, 0, 7'h00);
    check_ibi("R8 masked");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule